// File: doc/BRIEF.md
# Framebuffer Run-Length Fill Engine

This block paints a run of identical 16-bit words into a word-addressed framebuffer without a processor loop. Software sets a fill count and a starting word address through a small register write port, then writes the fill value. That last write launches the run. The engine then stores the value into consecutive words of the back buffer, which is the buffer not selected for display. It writes one word per clock and follows the memory's ready signal.

The address step carries only inside the low eight bits, so every run stays inside one 256-word row and wraps back to the row start. When the run ends, the start register holds the address that follows the last word written, so a second data write continues from there. While a run is in progress the register port reports not-ready. A writer must hold its request until the run has finished.

Top module: `fb_fill_engine`

## Requirements
- R1: A write with select code 0 loads the fill count from bits [7:0] of the write data; bits [15:8] are discarded.
- R2: A write with select code 1 loads the full 16-bit start word address.
- R3: A write with select code 2 loads the data register and, if the count is nonzero, starts a run in the next cycle: exactly count memory writes follow, each carrying the data value.
- R4: After each accepted memory write the address bits [7:0] increase by one modulo 256 and bits [15:8] stay the same.
- R5: When a run ends, the start register holds the address after the last written word and the data register holds the fill value.
- R6: mem_bank equals the inverse of fb_select as sampled on the launching write, and it holds that value for the whole run even if fb_select changes.
- R7: busy is high throughout a run and reg_wr_ready is low while busy; a register request presented while busy is not taken and changes no register.
- R8: A data write while the count is zero causes no memory write and leaves the start register unchanged; the data register still takes the value.
- R9: A memory write completes on each clock edge where mem_wr_en and mem_ready are both high; while mem_ready is low the address and data are held.
- R10: After synchronous reset, busy and mem_wr_en are low, reg_wr_ready is high and the count, start and data registers read zero.
- R11: A write with select code 3 is accepted and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write request |
| reg_sel | input | 2 | Register select: 0 count, 1 start, 2 data, 3 none |
| reg_wdata | input | 16 | Register write data |
| reg_wr_ready | output | 1 | High when a register request is taken this cycle |
| fb_select | input | 1 | Displayed buffer; runs go to the other one |
| busy | output | 1 | Run in progress |
| len_q | output | 8 | Fill count register |
| start_q | output | 16 | Start/running address register |
| data_q | output | 16 | Fill data register |
| mem_wr_en | output | 1 | Memory write request |
| mem_bank | output | 1 | Target buffer for the write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |

## Verification
A wrong remaining count shows up as a run that is one word long or short. busy falls in the wrong cycle, and the start register stops at the wrong address, so a per-clock comparison catches this on the first edge where the run ends early or goes on too long. A carry that leaks into bit 8 puts a wrong row on mem_addr as soon as a run crosses word 255 of a row. A bank latched at the wrong time, or not latched at all, changes mem_bank on the clock after fb_select toggles mid-run. Ignoring mem_ready moves the address during a stall on the very next cycle.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    localparam int FBF_ADDR_W = 16;
    localparam int FBF_DATA_W = 16;
    localparam int FBF_LEN_W  = 8;
    localparam int FBF_ROW_W  = 8;

    typedef logic [FBF_ADDR_W-1:0] fb_addr_t;
    typedef logic [FBF_DATA_W-1:0] fb_data_t;
    typedef logic [FBF_LEN_W-1:0]  fb_len_t;

    typedef enum logic [1:0] {
        SEL_LEN   = 2'd0,
        SEL_START = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     take;
        reg_sel_e sel;
        fb_data_t wdata;
    } reg_req_t;

    // Advance within the row: carry stops at the row boundary.
    function automatic fb_addr_t row_step(fb_addr_t a);
        fb_addr_t n;
        n = a;
        n[FBF_ROW_W-1:0] = a[FBF_ROW_W-1:0] + 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/fbf_regfile.sv
module fbf_regfile
    import fbf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req,
    input  logic     step,
    output fb_len_t  len_q,
    output fb_addr_t start_q,
    output fb_data_t data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            start_q <= '0;
            data_q  <= '0;
        end else begin
            if (req.take && req.sel == SEL_LEN)
                len_q <= req.wdata[FBF_LEN_W-1:0];
            if (req.take && req.sel == SEL_DATA)
                data_q <= req.wdata;
            if (req.take && req.sel == SEL_START)
                start_q <= fb_addr_t'(req.wdata);
            else if (step)
                start_q <= row_step(start_q);
        end
    end

endmodule

// File: rtl/fbf_sequencer.sv
module fbf_sequencer
    import fbf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    launch,
    input  fb_len_t len,
    input  logic    fb_select,
    input  logic    mem_ready,
    output logic    busy,
    output logic    bank,
    output logic    step
);

    fb_len_t remain;

    assign step = busy && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            bank   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (mem_ready) begin
                remain <= remain - 1'b1;
                if (remain == fb_len_t'(1))
                    busy <= 1'b0;
            end
        end else if (launch && len != '0) begin
            busy   <= 1'b1;
            remain <= len;
            bank   <= ~fb_select;
        end
    end

endmodule

// File: rtl/fb_fill_engine.sv
module fb_fill_engine
    import fbf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic        reg_wr_ready,
    input  logic        fb_select,
    output logic        busy,
    output logic [7:0]  len_q,
    output logic [15:0] start_q,
    output logic [15:0] data_q,
    output logic        mem_wr_en,
    output logic        mem_bank,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ready
);

    reg_req_t req;
    logic     step;
    logic     run;
    fb_len_t  len_r;
    fb_addr_t start_r;
    fb_data_t data_r;

    assign reg_wr_ready = ~run;
    assign req.take     = reg_wr_en && ~run;
    assign req.sel      = reg_sel_e'(reg_sel);
    assign req.wdata    = fb_data_t'(reg_wdata);

    fbf_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .step    (step),
        .len_q   (len_r),
        .start_q (start_r),
        .data_q  (data_r)
    );

    fbf_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (req.take && req.sel == SEL_DATA),
        .len       (len_r),
        .fb_select (fb_select),
        .mem_ready (mem_ready),
        .busy      (run),
        .bank      (mem_bank),
        .step      (step)
    );

    assign busy      = run;
    assign len_q     = len_r;
    assign start_q   = start_r;
    assign data_q    = data_r;
    assign mem_wr_en = run;
    assign mem_addr  = start_r;
    assign mem_wdata = data_r;

endmodule

// File: rtl/fbf_checker.sv
module fbf_checker
    import fbf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic [1:0]  reg_sel,
    input logic [15:0] reg_wdata,
    input logic        reg_wr_ready,
    input logic        busy,
    input logic [7:0]  len_q,
    input logic [15:0] start_q,
    input logic        mem_wr_en,
    input logic        mem_bank,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        mem_ready
);

    // R7
    busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !reg_wr_ready);

    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !mem_ready) |=> (mem_wr_en && $stable(mem_addr) && $stable(mem_wdata)));

    // R4
    row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_ready) |=>
            ((mem_addr[FBF_ROW_W-1:0] == $past(mem_addr[FBF_ROW_W-1:0]) + 8'd1) &&
             (mem_addr[FBF_ADDR_W-1:FBF_ROW_W] == $past(mem_addr[FBF_ADDR_W-1:FBF_ROW_W]))));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && $past(mem_wr_en)) |-> $stable(mem_bank));

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_ready && reg_sel == 2'd2 && len_q == 8'd0) |=>
            (!busy && $stable(start_q)));

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_ready && reg_sel == 2'd2 && len_q != 8'd0) |=>
            (busy && mem_addr == $past(start_q) && mem_wdata == $past(reg_wdata)));

    // R1
    len_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_ready && reg_sel == 2'd0) |=> (len_q == $past(reg_wdata[7:0])));

endmodule

bind fb_fill_engine fbf_checker u_fbf_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_en    (reg_wr_en),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .reg_wr_ready (reg_wr_ready),
    .busy         (busy),
    .len_q        (len_q),
    .start_q      (start_q),
    .mem_wr_en    (mem_wr_en),
    .mem_bank     (mem_bank),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ready    (mem_ready)
);

// File: tb/fb_fill_engine_tb.sv
`timescale 1ns/1ps
module fb_fill_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic        reg_wr_ready;
    logic        fb_select = 1'b0;
    logic        busy;
    logic [7:0]  len_q;
    logic [15:0] start_q;
    logic [15:0] data_q;
    logic        mem_wr_en;
    logic        mem_bank;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ready = 1'b1;

    always #5 clk = ~clk;

    fb_fill_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_wr_ready(reg_wr_ready), .fb_select(fb_select),
        .busy(busy), .len_q(len_q), .start_q(start_q), .data_q(data_q),
        .mem_wr_en(mem_wr_en), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int dut_wr_cnt = 0;
    bit started = 0;
    bit ready_rand = 0;

    // behavioural reference state
    bit          m_busy;
    bit          m_bank;
    int          m_len, m_rem;
    logic [15:0] m_start, m_data;
    logic [15:0] exp_mem [logic [16:0]];
    logic [15:0] dut_mem [logic [16:0]];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_busy = 0; m_bank = 0; m_len = 0; m_rem = 0;
            m_start = 16'h0; m_data = 16'h0;
        end else if (m_busy) begin
            if (mem_ready) begin
                exp_mem[{m_bank, m_start}] = m_data;
                m_start = {m_start[15:8], m_start[7:0] + 8'd1};
                m_rem = m_rem - 1;
                if (m_rem == 0) m_busy = 0;
            end
        end else if (reg_wr_en) begin
            case (reg_sel)
                2'd0: m_len = int'(reg_wdata[7:0]);
                2'd1: m_start = reg_wdata;
                2'd2: begin
                    m_data = reg_wdata;
                    if (m_len != 0) begin
                        m_busy = 1; m_rem = m_len; m_bank = !fb_select;
                    end
                end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(rst ? "R10" : "R7", "busy", 32'(busy), 32'(m_busy));
            chk(rst ? "R10" : "R7", "reg_wr_ready", 32'(reg_wr_ready), 32'(!m_busy));
            chk(rst ? "R10" : "R9", "mem_wr_en", 32'(mem_wr_en), 32'(m_busy));
            chk(rst ? "R10" : "R1", "len_q", 32'(len_q), 32'(m_len));
            chk(rst ? "R10" : "R4", "start_q", 32'(start_q), 32'(m_start));
            chk(rst ? "R10" : "R5", "data_q", 32'(data_q), 32'(m_data));
            if (m_busy && !rst) begin
                chk("R4", "mem_addr", 32'(mem_addr), 32'(m_start));
                chk("R3", "mem_wdata", 32'(mem_wdata), 32'(m_data));
                chk("R6", "mem_bank", 32'(mem_bank), 32'(m_bank));
            end
            if (!rst && mem_wr_en && mem_ready) begin
                dut_mem[{mem_bank, mem_addr}] = mem_wdata;
                dut_wr_cnt++;
            end
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] d);
        bit acc;
        @(posedge clk); #2;
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        forever begin
            @(negedge clk); acc = reg_wr_ready;
            @(posedge clk);
            if (acc) break;
        end
        #2 reg_wr_en = 1'b0;
    endtask

    task automatic reg_poke(input logic [1:0] sel, input logic [15:0] d);
        @(posedge clk); #2;
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // memory ready pattern
    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        forever begin
            @(posedge clk); #2;
            if (ready_rand) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                mem_ready = lfsr[0];
            end else begin
                mem_ready = 1'b1;
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int snap;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R10", "busy after reset", 32'(busy), 32'd0);
        chk("R10", "start after reset", 32'(start_q), 32'd0);

        // R1 R2 R3 R4 R5: count high byte dropped, run wraps inside the row
        reg_write(2'd0, 16'hAB05);
        reg_write(2'd1, 16'h12FE);
        fb_select = 1'b0;
        reg_write(2'd2, 16'hBEEF);
        wait_idle();
        chk("R1", "count low byte", 32'(len_q), 32'h05);
        chk("R5", "start after run", 32'(start_q), 32'h1203);
        chk("R5", "data after run", 32'(data_q), 32'hBEEF);
        chk("R3", "write count", 32'(dut_wr_cnt), 32'd5);

        // R9 R7 R6: ready stalls, ignored requests, display flip mid-run
        ready_rand = 1;
        reg_write(2'd0, 16'h0010);
        reg_write(2'd1, 16'h3400);
        fb_select = 1'b1;
        reg_write(2'd2, 16'h5A5A);
        reg_poke(2'd0, 16'h00FF);
        reg_poke(2'd1, 16'hFFFF);
        fb_select = 1'b0;
        wait_idle();
        ready_rand = 0;
        chk("R7", "count untouched by stalled request", 32'(len_q), 32'h10);
        chk("R7", "start untouched by stalled request", 32'(start_q), 32'h3410);
        chk("R6", "bank-0 word written", 32'(dut_mem.exists({1'b0, 16'h340F})), 32'd1);

        // R8: zero count
        snap = dut_wr_cnt;
        reg_write(2'd0, 16'h0000);
        reg_write(2'd2, 16'h7777);
        repeat (3) @(negedge clk);
        chk("R8", "no writes", 32'(dut_wr_cnt), 32'(snap));
        chk("R8", "start unchanged", 32'(start_q), 32'h3410);
        chk("R8", "data taken", 32'(data_q), 32'h7777);

        // R11: select code 3
        reg_write(2'd3, 16'hFFFF);
        @(negedge clk);
        chk("R11", "count", 32'(len_q), 32'h00);
        chk("R11", "start", 32'(start_q), 32'h3410);
        chk("R11", "data", 32'(data_q), 32'h7777);

        // R4 R5: 255-word run from the middle of a row
        reg_write(2'd0, 16'h00FF);
        reg_write(2'd1, 16'h4580);
        reg_write(2'd2, 16'h0F0F);
        wait_idle();
        chk("R5", "start after long run", 32'(start_q), 32'h457F);
        chk("R4", "row start written", 32'(dut_mem[{1'b1, 16'h4500}]), 32'h0F0F);

        // R3: full memory image
        chk("R3", "image size", 32'(dut_mem.size()), 32'(exp_mem.size()));
        foreach (exp_mem[k]) begin
            if (!dut_mem.exists(k)) chk("R3", "missing word", 32'(k), 32'h1FFFF);
            else if (dut_mem[k] !== exp_mem[k]) chk("R3", "word value", 32'(dut_mem[k]), 32'(exp_mem[k]));
        end
        finish_run();
    end

endmodule